// File: doc/BRIEF.md
# NAND Page Program and Erase Emulator

This block holds a scaled-down NAND flash array in on-chip storage and lets a host program pages, read pages and erase blocks through a small command port. The flash rules are enforced, not just modelled: a program can only clear bits, so the stored byte becomes the old byte ANDed with the written byte. Only a block erase brings bits back to one, and only for a whole block at once. Each page counts its partial programs, and once the count reaches the limit any further program is refused until the block is erased.

A page is a data area followed by a spare area, kept at the usual 32:1 ratio (64 data bytes and 2 spare bytes by default). A block holds 32 or 64 pages, chosen by a parameter. The first two spare bytes of a block's first page serve as its bad-block marker. If they are not both 0xFF, the block refuses program and erase commands. It can still be read.

Every command ends with one status beat. Page contents move over byte-wide valid/ready streams: one for write data in and one for read data out, with a last flag on the final read byte.

Top module: `nand_emu`

## Requirements
- R1: After reset every byte of every page reads 0xFF, all program counters are zero, and only `cmd_ready` is high among `cmd_ready`, `wr_ready`, `rd_valid` and `st_valid`.
- R2: An accepted program stores, for each byte of the page, the old byte ANDed with the written byte; a later program can never turn a 0 bit back to 1.
- R3: An accepted erase sets every byte of every page of the addressed block to 0xFF and reports status OK (code 0); pages of other blocks are unchanged.
- R4: A read with status OK streams exactly PAGE_BYTES bytes, the data area at byte offsets 0 to DATA_BYTES-1 first and then the spare area. `rd_last` is high only on the final byte, and the OK status beat follows it.
- R5: A page accepts PROG_LIMIT (DATA_BYTES/SUBPAGE_BYTES, default 4) programs between erases. The next program returns PROGRAM_LIMIT (code 1) and leaves the page unchanged. An erase of its block resets the count to zero.
- R6: A block is bad when byte offset DATA_BYTES or DATA_BYTES+1 of its page 0 is not 0xFF. Program and erase on a bad block return BAD_BLOCK (code 2) and change nothing, and reads of it still return the stored contents.
- R7: A block number of BLOCKS or more, or a page number of PAGES_PER_BLOCK or more, returns ADDRESS_RANGE (code 3). This check ranks above BAD_BLOCK, which ranks above PROGRAM_LIMIT. A read with a non-OK status streams no bytes.
- R8: At most one of `cmd_ready`, `wr_ready`, `rd_valid`, `st_valid` is high at a time. `rd_data`/`rd_last` and `st_code` hold steady while their valid is high and ready is low. After a status beat is taken, the block is ready for the next command.
- R9: A program command always takes exactly PAGE_BYTES write beats, whatever its status, and then gives its status beat. Beats of a refused program are discarded.
- R10: Command encoding: `cmd_op` bit 1 set selects erase; otherwise bit 0 set selects program; otherwise the command is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this cycle when both high |
| cmd_op | input | 2 | Operation select (R10) |
| cmd_block | input | $clog2(BLOCKS)+1 | Block number |
| cmd_page | input | $clog2(PAGES_PER_BLOCK)+1 | Page number within the block |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken when both high |
| wr_data | input | 8 | Page byte to program |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Read byte taken when both high |
| rd_data | output | 8 | Page byte read |
| rd_last | output | 1 | Final byte of the page |
| st_valid | output | 1 | Status offered |
| st_ready | input | 1 | Status taken when both high |
| st_code | output | 2 | 0 OK, 1 PROGRAM_LIMIT, 2 BAD_BLOCK, 3 ADDRESS_RANGE |

## Verification
Programs are tried with the all-ones pattern, with two overlapping patterns on the same page, and with random mostly-ones bytes. These show whether the stored value is a true AND or a plain overwrite. Repeated programs of one page show whether the limit falls at exactly four. Erases followed by reads of the erased block and of the other block show whether an erase reaches past its own block. Marking a block bad, and using addresses just past the last block and page, show whether the status priority is right and whether refused commands change anything. Random stalls on every ready show whether the stream outputs stay stable under back-pressure.

// File: rtl/nand_emu_pkg.sv
`timescale 1ns/1ps
// Shared types for the NAND emulator: status codes, decoded operations
// and controller states. Assumes a two-bit raw operation field.
package nand_emu_pkg;

    typedef enum logic [1:0] {
        ST_OK         = 2'd0,
        ST_PROG_LIMIT = 2'd1,
        ST_BAD_BLOCK  = 2'd2,
        ST_ADDR_RANGE = 2'd3
    } status_e;

    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_PROGRAM = 2'd1,
        OP_ERASE   = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_PROG   = 2'd1,
        S_READ   = 2'd2,
        S_STATUS = 2'd3
    } state_e;

    // Bit 1 wins (erase), then bit 0 (program), else read.
    function automatic op_e decode_op(input logic [1:0] raw);
        if (raw[1])      return OP_ERASE;
        else if (raw[0]) return OP_PROGRAM;
        else             return OP_READ;
    endfunction

endpackage

// File: rtl/nand_page_store.sv
`timescale 1ns/1ps
// Byte storage for all pages plus one "live" flag per page.
// A page whose flag is clear reads as all ones, so a block erase only
// clears flags instead of rewriting every byte. Programs AND the new
// byte into the old one. Assumes PAGES is a power of two, so that a
// page index is {block, page}, and that erase and commit never coincide.
module nand_page_store #(
    parameter int BLOCKS     = 2,
    parameter int PAGES      = 32,
    parameter int DATA_BYTES = 64,
    parameter int PAGE_BYTES = 66
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [$clog2(BLOCKS*PAGES)-1:0]       acc_page,
    input  logic [$clog2(PAGE_BYTES)-1:0]         acc_byte,
    output logic [7:0]                            acc_rdata,
    input  logic                                  wr_en,
    input  logic [7:0]                            wr_data,
    input  logic                                  commit_en,
    input  logic                                  erase_en,
    input  logic [$clog2(BLOCKS)-1:0]             erase_blk,
    input  logic [$clog2(BLOCKS)-1:0]             chk_blk,
    output logic                                  marker_ok
);
    localparam int TOTAL_PAGES = BLOCKS * PAGES;
    localparam int TOTAL_BYTES = TOTAL_PAGES * PAGE_BYTES;
    localparam int PIDX_W      = $clog2(TOTAL_PAGES);
    localparam int BYTE_W      = $clog2(PAGE_BYTES);
    localparam int PG_W        = $clog2(PAGES);
    localparam int ADDR_W      = $clog2(TOTAL_BYTES);

    logic [7:0]             mem [TOTAL_BYTES];
    logic [TOTAL_PAGES-1:0] page_live;
    logic [ADDR_W-1:0]      acc_addr;
    logic [7:0]             old_byte;
    logic [PIDX_W-1:0]      mark_page;
    logic [ADDR_W-1:0]      mark_addr0;
    logic [ADDR_W-1:0]      mark_addr1;

    function automatic logic [ADDR_W-1:0] flat(input logic [PIDX_W-1:0] pidx,
                                               input logic [BYTE_W-1:0] bidx);
        return ADDR_W'(pidx) * ADDR_W'(PAGE_BYTES) + ADDR_W'(bidx);
    endfunction

    // Address and current value of the byte under access.
    always_comb begin
        acc_addr  = flat(acc_page, acc_byte);
        old_byte  = page_live[acc_page] ? mem[acc_addr] : 8'hFF;
        acc_rdata = old_byte;
    end

    // Bad-block marker: first two spare bytes of page 0 of the checked block.
    always_comb begin
        mark_page  = {chk_blk, PG_W'(0)};
        mark_addr0 = flat(mark_page, BYTE_W'(DATA_BYTES));
        mark_addr1 = flat(mark_page, BYTE_W'(DATA_BYTES + 1));
        marker_ok  = !page_live[mark_page] ||
                     ((mem[mark_addr0] == 8'hFF) && (mem[mark_addr1] == 8'hFF));
    end

    // Byte array: program only clears bits (no reset, gated by page_live).
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[acc_addr] <= old_byte & wr_data;
        end
    end

    // Live flags: set when a program completes, cleared per block on erase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_live <= '0;
        end else begin
            if (commit_en) begin
                page_live[acc_page] <= 1'b1;
            end
            for (int p = 0; p < TOTAL_PAGES; p++) begin
                if (erase_en && (p / PAGES) == int'(erase_blk)) begin
                    page_live[p] <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/nand_wear_table.sv
`timescale 1ns/1ps
// Per-page count of partial programs since the last erase of its block.
// Reports whether the queried page has reached the limit. Assumes
// PAGES is a power of two and that increment and clear never coincide.
module nand_wear_table #(
    parameter int BLOCKS     = 2,
    parameter int PAGES      = 32,
    parameter int PROG_LIMIT = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [$clog2(BLOCKS*PAGES)-1:0]   q_page,
    output logic                              at_limit,
    input  logic                              inc_en,
    input  logic [$clog2(BLOCKS*PAGES)-1:0]   inc_page,
    input  logic                              clr_en,
    input  logic [$clog2(BLOCKS)-1:0]         clr_blk
);
    localparam int TOTAL_PAGES = BLOCKS * PAGES;
    localparam int CNT_W       = $clog2(PROG_LIMIT + 1);

    logic [CNT_W-1:0] prog_cnt [TOTAL_PAGES];

    // Limit lookup for the page named by an incoming command.
    always_comb begin
        at_limit = prog_cnt[q_page] >= CNT_W'(PROG_LIMIT);
    end

    // Count completed programs; zero a whole block's counts on erase.
    always_ff @(posedge clk) begin
        for (int p = 0; p < TOTAL_PAGES; p++) begin
            if (!rst_n) begin
                prog_cnt[p] <= '0;
            end else if (clr_en && (p / PAGES) == int'(clr_blk)) begin
                prog_cnt[p] <= '0;
            end else if (inc_en && p == int'(inc_page)) begin
                prog_cnt[p] <= prog_cnt[p] + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/nand_cmd_ctrl.sv
`timescale 1ns/1ps
// Command sequencer: decodes a command, ranks its status (range, then
// bad block, then program limit), runs the write or read byte stream
// and offers one status beat. Assumes PAGES is a power of two and
// BLOCKS is at least two.
module nand_cmd_ctrl
    import nand_emu_pkg::*;
#(
    parameter int BLOCKS     = 2,
    parameter int PAGES      = 32,
    parameter int PAGE_BYTES = 66
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cmd_valid,
    output logic                                  cmd_ready,
    input  logic [1:0]                            cmd_op,
    input  logic [$clog2(BLOCKS):0]               cmd_block,
    input  logic [$clog2(PAGES):0]                cmd_page,
    input  logic                                  wr_valid,
    output logic                                  wr_ready,
    output logic                                  rd_valid,
    input  logic                                  rd_ready,
    output logic                                  rd_last,
    output logic                                  st_valid,
    input  logic                                  st_ready,
    output logic [1:0]                            st_code,
    input  logic                                  marker_ok,
    input  logic                                  at_limit,
    output logic [$clog2(BLOCKS*PAGES)-1:0]       mem_page,
    output logic [$clog2(PAGE_BYTES)-1:0]         mem_byte,
    output logic                                  mem_wr_en,
    output logic                                  commit_en,
    output logic                                  erase_en,
    output logic [$clog2(BLOCKS)-1:0]             erase_blk
);
    localparam int BLK_W     = $clog2(BLOCKS);
    localparam int PG_W      = $clog2(PAGES);
    localparam int PIDX_W    = $clog2(BLOCKS * PAGES);
    localparam int BYTE_W    = $clog2(PAGE_BYTES);
    localparam int LAST_BYTE = PAGE_BYTES - 1;

    state_e            state;
    status_e           code;
    status_e           new_code;
    op_e               op;
    logic              do_write;
    logic [PIDX_W-1:0] cur_pidx;
    logic [BYTE_W-1:0] byte_idx;
    logic              at_last;
    logic              blk_in_range;
    logic              pg_in_range;
    logic              accept;

    // Block range check: one bit for a power-of-two count, else compare.
    generate
        if ((BLOCKS & (BLOCKS - 1)) == 0) begin : g_blk_pow2
            assign blk_in_range = ~cmd_block[BLK_W];
        end else begin : g_blk_cmp
            assign blk_in_range = cmd_block < (BLK_W + 1)'(BLOCKS);
        end
    endgenerate

    // Page number is in range when its extra top bit is clear.
    assign pg_in_range = ~cmd_page[PG_W];

    // Rank the status of the incoming command.
    always_comb begin
        op = decode_op(cmd_op);
        if (!(blk_in_range && pg_in_range))      new_code = ST_ADDR_RANGE;
        else if (op != OP_READ && !marker_ok)    new_code = ST_BAD_BLOCK;
        else if (op == OP_PROGRAM && at_limit)   new_code = ST_PROG_LIMIT;
        else                                     new_code = ST_OK;
    end

    // Handshake outputs and storage controls decoded from the state.
    always_comb begin
        accept    = (state == S_IDLE) && cmd_valid;
        at_last   = byte_idx == BYTE_W'(LAST_BYTE);
        cmd_ready = state == S_IDLE;
        wr_ready  = state == S_PROG;
        rd_valid  = state == S_READ;
        rd_last   = rd_valid && at_last;
        st_valid  = state == S_STATUS;
        st_code   = code;
        mem_page  = cur_pidx;
        mem_byte  = byte_idx;
        mem_wr_en = wr_ready && wr_valid && do_write;
        commit_en = mem_wr_en && at_last;
        erase_en  = accept && op == OP_ERASE && new_code == ST_OK;
        erase_blk = cmd_block[BLK_W-1:0];
    end

    // Sequencer: latch the command, walk the page bytes, hand out status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            code     <= ST_OK;
            do_write <= 1'b0;
            cur_pidx <= '0;
            byte_idx <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (cmd_valid) begin
                        cur_pidx <= {cmd_block[BLK_W-1:0], cmd_page[PG_W-1:0]};
                        code     <= new_code;
                        byte_idx <= '0;
                        do_write <= (op == OP_PROGRAM) && (new_code == ST_OK);
                        if (op == OP_PROGRAM)
                            state <= S_PROG;
                        else if (op == OP_READ && new_code == ST_OK)
                            state <= S_READ;
                        else
                            state <= S_STATUS;
                    end
                end
                S_PROG: begin
                    if (wr_valid) begin
                        byte_idx <= byte_idx + BYTE_W'(1);
                        if (at_last) state <= S_STATUS;
                    end
                end
                S_READ: begin
                    if (rd_ready) begin
                        byte_idx <= byte_idx + BYTE_W'(1);
                        if (at_last) state <= S_STATUS;
                    end
                end
                default: begin
                    if (st_ready) state <= S_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/nand_emu.sv
`timescale 1ns/1ps
// NAND page program/erase emulator top. Page = DATA_BYTES data bytes
// plus DATA_BYTES/32 spare bytes; PAGES_PER_BLOCK must be 32 or 64;
// BLOCKS at least two; DATA_BYTES a multiple of 32 and of SUBPAGE_BYTES.
module nand_emu #(
    parameter int BLOCKS          = 2,
    parameter int PAGES_PER_BLOCK = 32,
    parameter int DATA_BYTES      = 64,
    parameter int SUBPAGE_BYTES   = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cmd_valid,
    output logic                                 cmd_ready,
    input  logic [1:0]                           cmd_op,
    input  logic [$clog2(BLOCKS):0]              cmd_block,
    input  logic [$clog2(PAGES_PER_BLOCK):0]     cmd_page,
    input  logic                                 wr_valid,
    output logic                                 wr_ready,
    input  logic [7:0]                           wr_data,
    output logic                                 rd_valid,
    input  logic                                 rd_ready,
    output logic [7:0]                           rd_data,
    output logic                                 rd_last,
    output logic                                 st_valid,
    input  logic                                 st_ready,
    output logic [1:0]                           st_code
);
    localparam int SPARE_BYTES = DATA_BYTES / 32;
    localparam int PAGE_BYTES  = DATA_BYTES + SPARE_BYTES;
    localparam int PROG_LIMIT  = DATA_BYTES / SUBPAGE_BYTES;
    localparam int BLK_W       = $clog2(BLOCKS);
    localparam int PG_W        = $clog2(PAGES_PER_BLOCK);
    localparam int PIDX_W      = $clog2(BLOCKS * PAGES_PER_BLOCK);
    localparam int BYTE_W      = $clog2(PAGE_BYTES);

    logic              marker_ok;
    logic              at_limit;
    logic [PIDX_W-1:0] mem_page;
    logic [BYTE_W-1:0] mem_byte;
    logic              mem_wr_en;
    logic              commit_en;
    logic              erase_en;
    logic [BLK_W-1:0]  erase_blk;
    logic [PIDX_W-1:0] cmd_pidx;

    // Page index named by the command on the port, for the limit lookup.
    assign cmd_pidx = {cmd_block[BLK_W-1:0], cmd_page[PG_W-1:0]};

    nand_cmd_ctrl #(
        .BLOCKS     (BLOCKS),
        .PAGES      (PAGES_PER_BLOCK),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_op    (cmd_op),
        .cmd_block (cmd_block),
        .cmd_page  (cmd_page),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .rd_valid  (rd_valid),
        .rd_ready  (rd_ready),
        .rd_last   (rd_last),
        .st_valid  (st_valid),
        .st_ready  (st_ready),
        .st_code   (st_code),
        .marker_ok (marker_ok),
        .at_limit  (at_limit),
        .mem_page  (mem_page),
        .mem_byte  (mem_byte),
        .mem_wr_en (mem_wr_en),
        .commit_en (commit_en),
        .erase_en  (erase_en),
        .erase_blk (erase_blk)
    );

    nand_page_store #(
        .BLOCKS     (BLOCKS),
        .PAGES      (PAGES_PER_BLOCK),
        .DATA_BYTES (DATA_BYTES),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_page  (mem_page),
        .acc_byte  (mem_byte),
        .acc_rdata (rd_data),
        .wr_en     (mem_wr_en),
        .wr_data   (wr_data),
        .commit_en (commit_en),
        .erase_en  (erase_en),
        .erase_blk (erase_blk),
        .chk_blk   (cmd_block[BLK_W-1:0]),
        .marker_ok (marker_ok)
    );

    nand_wear_table #(
        .BLOCKS     (BLOCKS),
        .PAGES      (PAGES_PER_BLOCK),
        .PROG_LIMIT (PROG_LIMIT)
    ) u_wear (
        .clk      (clk),
        .rst_n    (rst_n),
        .q_page   (cmd_pidx),
        .at_limit (at_limit),
        .inc_en   (commit_en),
        .inc_page (mem_page),
        .clr_en   (erase_en),
        .clr_blk  (erase_blk)
    );

endmodule

// File: rtl/nand_emu_checker.sv
`timescale 1ns/1ps
// Protocol checker for nand_emu, watching only its ports. Bound to
// every nand_emu instance below.
module nand_emu_checker #(
    parameter int BLOCKS          = 2,
    parameter int PAGES_PER_BLOCK = 32
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              cmd_valid,
    input logic                              cmd_ready,
    input logic [1:0]                        cmd_op,
    input logic [$clog2(BLOCKS):0]           cmd_block,
    input logic [$clog2(PAGES_PER_BLOCK):0]  cmd_page,
    input logic                              wr_ready,
    input logic                              rd_valid,
    input logic                              rd_ready,
    input logic [7:0]                        rd_data,
    input logic                              rd_last,
    input logic                              st_valid,
    input logic                              st_ready,
    input logic [1:0]                        st_code
);
    // R8: only one channel is active at a time.
    assert_one_channel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_ready, wr_ready, rd_valid, st_valid}));

    // R8: a stalled read byte holds.
    assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_last));

    // R8: a stalled status holds.
    assert_st_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && !st_ready |=> st_valid && $stable(st_code));

    // R8: after status is taken the block takes commands again.
    assert_back_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && st_ready |=> cmd_ready);

    // R4: last only with a valid byte; the final byte is followed by OK.
    assert_last_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);
    assert_read_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_ready && rd_last |=> st_valid && st_code == 2'd0);

    // R7: a read of a block past the end goes straight to ADDRESS_RANGE.
    assert_range_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_op == 2'd0 && int'(cmd_block) >= BLOCKS
        |=> st_valid && st_code == 2'd3);

    // R10: an erase (op bit 1) answers with status in the next cycle.
    assert_erase_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_op[1] |=> st_valid);

endmodule

bind nand_emu nand_emu_checker #(
    .BLOCKS          (BLOCKS),
    .PAGES_PER_BLOCK (PAGES_PER_BLOCK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_block (cmd_block),
    .cmd_page  (cmd_page),
    .wr_ready  (wr_ready),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .rd_last   (rd_last),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .st_code   (st_code)
);

// File: tb/nand_emu_bench.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases, then seeded random
// commands, compared against a byte-level model held in the bench.
module nand_emu_bench;
    localparam int NB  = 2;
    localparam int NP  = 32;
    localparam int DB  = 64;
    localparam int PB  = 66;
    localparam int LIM = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid, cmd_ready;
    logic [1:0] cmd_op;
    logic [1:0] cmd_block;
    logic [5:0] cmd_page;
    logic       wr_valid, wr_ready;
    logic [7:0] wr_data;
    logic       rd_valid, rd_ready, rd_last;
    logic [7:0] rd_data;
    logic       st_valid, st_ready;
    logic [1:0] st_code;

    int tests = 0;
    int fails = 0;

    logic [7:0] model [NB][NP][PB];
    int         pcnt  [NB][NP];
    logic [7:0] wbuf  [PB];

    always #2.5 clk = ~clk;

    nand_emu u_nand_emu (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_block(cmd_block), .cmd_page(cmd_page),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
        .st_valid(st_valid), .st_ready(st_ready), .st_code(st_code)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int model_code(input int op, input int blk, input int pg);
        bit erase = (op & 2) != 0;
        bit prog  = !erase && (op & 1) != 0;
        if (blk >= NB || pg >= NP) return 3;
        if ((erase || prog) && !(model[blk][0][DB] == 8'hFF && model[blk][0][DB+1] == 8'hFF))
            return 2;
        if (prog && pcnt[blk][pg] >= LIM) return 1;
        return 0;
    endfunction

    // Issue one command, move its bytes, compare status and read data.
    task automatic run_op(input int op, input int blk, input int pg, input string req);
        int exp_code = model_code(op, blk, pg);
        bit erase = (op & 2) != 0;
        bit prog  = !erase && (op & 1) != 0;
        int n = 0;
        int bad_bytes = 0;
        int first_bad = -1;
        int last_err = 0;
        int got_code;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_block = blk[1:0]; cmd_page = pg[5:0];
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (prog) begin
            for (int i = 0; i < PB; i++) begin
                if ($urandom % 5 == 0) begin
                    wr_valid = 1'b0;
                    @(negedge clk);
                end
                wr_valid = 1'b1; wr_data = wbuf[i];
                while (!wr_ready) @(negedge clk);
                @(negedge clk);
            end
            wr_valid = 1'b0;
            while (!st_valid) @(negedge clk);
        end else begin
            while (!st_valid) begin
                rd_ready = ($urandom % 4) != 0;
                if (rd_valid && rd_ready) begin
                    if (n < PB && exp_code == 0 && rd_data != model[blk][pg][n]) begin
                        bad_bytes++;
                        if (first_bad < 0) first_bad = n;
                    end
                    if (rd_last != (n == PB - 1)) last_err++;
                    n++;
                end
                @(negedge clk);
            end
            rd_ready = 1'b0;
        end
        repeat ($urandom % 3) @(negedge clk);
        got_code = int'(st_code);
        st_ready = 1'b1;
        @(negedge clk);
        st_ready = 1'b0;
        check(got_code == exp_code, req, "status", got_code, exp_code);
        if (!prog && !erase) begin
            check(n == ((exp_code == 0) ? PB : 0), req, "read byte count", n,
                  (exp_code == 0) ? PB : 0);
            if (exp_code == 0) begin
                check(bad_bytes == 0, req, "read data first bad byte", first_bad, -1);
                check(last_err == 0, "R4", "rd_last misplaced beats", last_err, 0);
            end
        end
        if (exp_code == 0 && prog) begin
            for (int i = 0; i < PB; i++) model[blk][pg][i] &= wbuf[i];
            pcnt[blk][pg]++;
        end
        if (exp_code == 0 && erase) begin
            for (int p = 0; p < NP; p++) begin
                pcnt[blk][p] = 0;
                for (int i = 0; i < PB; i++) model[blk][p][i] = 8'hFF;
            end
        end
    endtask

    task automatic fill(input int kind);
        for (int i = 0; i < PB; i++) begin
            case (kind)
                0: wbuf[i] = 8'hFF;
                1: wbuf[i] = 8'hF0 ^ 8'(i);
                2: wbuf[i] = 8'h3C | 8'(i * 3);
                default: wbuf[i] = 8'($urandom | $urandom);
            endcase
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R8 watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_block = '0; cmd_page = '0;
        wr_valid = 1'b0; wr_data = '0; rd_ready = 1'b0; st_ready = 1'b0;
        for (int b = 0; b < NB; b++)
            for (int p = 0; p < NP; p++) begin
                pcnt[b][p] = 0;
                for (int i = 0; i < PB; i++) model[b][p][i] = 8'hFF;
            end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of the handshake outputs.
        check(cmd_ready && !wr_ready && !rd_valid && !st_valid, "R1", "idle after reset",
              {cmd_ready, wr_ready, rd_valid, st_valid}, 4'b1000);
        run_op(0, 0, 0, "R1");
        run_op(0, 1, NP - 1, "R1");

        // R2: program then overlapping program gives the AND.
        fill(1); run_op(1, 0, 3, "R2");
        run_op(0, 0, 3, "R2");
        fill(2); run_op(1, 0, 3, "R2");
        run_op(0, 0, 3, "R2");

        // R5: two more programs reach the limit; the fifth is refused.
        fill(0); run_op(1, 0, 3, "R5");
        fill(3); wbuf[DB] = 8'hFF; wbuf[DB+1] = 8'hFF; run_op(1, 0, 3, "R5");
        fill(3); run_op(1, 0, 3, "R5");
        run_op(0, 0, 3, "R5");

        // R3: erase block 0 keeps block 1; count resets (R5).
        fill(2); run_op(1, 1, 5, "R3");
        run_op(2, 0, 0, "R3");
        run_op(0, 0, 3, "R3");
        run_op(0, 1, 5, "R3");
        fill(1); run_op(1, 0, 3, "R5");
        run_op(0, 0, 3, "R5");

        // R10: op 3 behaves as erase.
        run_op(3, 0, 7, "R10");
        run_op(0, 0, 3, "R10");

        // R6: mark block 1 bad, then program and erase are refused.
        fill(0); wbuf[DB] = 8'h00; run_op(1, 1, 0, "R6");
        fill(1); run_op(1, 1, 2, "R6");
        run_op(2, 1, 0, "R6");
        run_op(0, 1, 5, "R6");
        run_op(0, 1, 0, "R6");
        run_op(0, 1, 2, "R6");

        // R7 and R9: out-of-range addresses; programs still eat the stream.
        run_op(0, 2, 0, "R7");
        run_op(0, 0, NP, "R7");
        fill(3); run_op(1, 0, NP, "R9");
        run_op(2, 3, 0, "R7");
        fill(3); run_op(1, 3, 63, "R7");
        run_op(0, 0, 3, "R9");

        // Random mix on block 0 and 1 pages 0..3, some out-of-range.
        for (int k = 0; k < 160; k++) begin
            int r   = $urandom % 10;
            int op  = (r < 4) ? 1 : (r < 8) ? 0 : 2;
            int blk = $urandom % 2;
            int pg  = $urandom % 4;
            if ($urandom % 12 == 0) pg = NP + ($urandom % 2);
            fill(3);
            wbuf[DB] = 8'hFF; wbuf[DB+1] = 8'hFF;
            run_op(op, blk, pg, (op == 1) ? "R2" : (op == 0) ? "R4" : "R3");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule